// File: doc/BRIEF.md
# Signed 64-by-32 Sequential Integer Divider

This block divides a 64-bit two's-complement dividend by a 32-bit two's-complement divisor for a 32-bit register machine. The dividend is formed from a register pair: the even register supplies the upper word and the odd register the lower word. A one-cycle `start` pulse loads both operands. The block then produces a 32-bit quotient, which goes back to the odd register, and a 32-bit remainder, which goes back to the even register. The quotient is truncated toward zero, so the remainder carries the sign of the dividend.

The divider works on magnitudes. It takes one quotient bit per clock using a radix-2 restoring step, then applies the signs in a final cycle. Before it iterates, it checks the divisor for zero and screens the dividend's upper half for a quotient that cannot fit. A quotient that lies between 2^31 and 2^32 is found after the iterations. On either exception the result outputs keep their previous values, so the register pair is left untouched. Only a flag is raised.

Top module: `signedDivider`

## Requirements
- R1: `dividend[63:32]` is the high (even-register) word and `dividend[31:0]` the low (odd-register) word. When a division completes normally, `quotient` holds the odd-register result and `remainder` the even-register result. Example: 19/5 gives remainder 4 and quotient 3.
- R2: The quotient is truncated toward zero. It is negative only when exactly one operand is negative. Example: -19/5 gives quotient 0xFFFFFFFD.
- R3: The remainder is zero or has the sign of the dividend, and its magnitude is below the divisor's. Example: -100/-8 gives remainder 0xFFFFFFFC and quotient 0x0000000C.
- R4: A zero divisor sets `zeroDivide`, leaves `overflow` low, and `done` rises after edge 1. The edge that samples the accepted `start` counts as edge 0.
- R5: If the quotient magnitude is 2^32 or more, the block sets `overflow`, and `done` rises after edge 1.
- R6: If the quotient magnitude lies in [2^31, 2^32), the block sets `overflow`, and `done` rises after edge 34. This includes a positive quotient of +2^31. The one exception is a negative quotient of exactly -2^31.
- R7: A quotient of exactly -2^31 is a valid result (0x80000000) and raises no flag.
- R8: On a zero divisor or an overflow, `quotient` and `remainder` keep the values they held before the start.
- R9: A `start` pulse while `busy` is high is ignored. The running division completes with its own operands and timing, and no extra `done` appears.
- R10: A non-exception division raises `done` after edge 34. `done` lasts one cycle. `busy` is high from after edge 0 until `done` rises, and is never high together with `done`.
- R11: After reset all outputs are 0. An accepted `start` clears `zeroDivide` and `overflow` after edge 0. Flags and results then hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; accepted only while not busy |
| dividend | input | 64 | Two's-complement dividend: even register high, odd register low |
| divisor | input | 32 | Two's-complement divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient for the odd register |
| remainder | output | 32 | Remainder for the even register |
| zeroDivide | output | 1 | Last division had a zero divisor |
| overflow | output | 1 | Last division's quotient did not fit in 32 signed bits |

## Verification
Counting the edge that samples `start` as edge 0, results fall into two timing classes:
- Zero-divisor and early-overflow outcomes are due after edge 1.
- Normal results and late overflows are due after edge 34.

The driver records the free-running cycle count when it raises `start`. It stores the absolute due cycle with the expected item. The monitor samples `done` on falling edges and compares the arrival cycle against that stored value, as well as the data and flags. The flag clearing is checked on the falling edge right after edge 0. Each expected item is computed with wide signed arithmetic, not with the restoring algorithm.

// File: rtl/divPkg.sv
package divPkg;

  // Controller states: capture happens on the IDLE->SETUP edge.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIX   = 2'd3
  } divState_t;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;   // capture operands, clear flags
    logic setup;  // screen for zero / early overflow, seed iteration
    logic step;   // one restoring iteration
    logic fix;    // late overflow check and sign correction
  } divStrobes_t;

endpackage

// File: rtl/divMagnitude.sv
module divMagnitude #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output logic         negative,
  output logic [W-1:0] magnitude
);
  // Unsigned magnitude of a two's-complement value; the most negative
  // value maps to 2^(W-1), which still fits in W unsigned bits.
  assign negative  = value[W-1];
  assign magnitude = negative ? (~value + W'(1)) : value;
endmodule

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        setupFail,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int              CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  divState_t        state;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    strobes.load  = (state == ST_IDLE) && start;
    strobes.setup = (state == ST_SETUP);
    strobes.step  = (state == ST_RUN);
    strobes.fix   = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (setupFail) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          if (iterCnt == LAST) state <= ST_FIX;
          else                 iterCnt <= iterCnt + CNT_W'(1);
        end
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  divStrobes_t           strobes,
  input  logic [2*WORD_W-1:0]   dividend,
  input  logic [WORD_W-1:0]     divisor,
  output logic                  setupFail,
  output logic [WORD_W-1:0]     quotient,
  output logic [WORD_W-1:0]     remainder,
  output logic                  zeroDivide,
  output logic                  overflow
);
  localparam int DVD_W = 2 * WORD_W;
  localparam logic [WORD_W-1:0] MSB_ONLY = {1'b1, {(WORD_W-1){1'b0}}};

  // Captured operands
  logic [DVD_W-1:0]  dvdReg;
  logic [WORD_W-1:0] dvsReg;

  // Iteration state
  logic [WORD_W-1:0] partRem;   // partial remainder magnitude
  logic [WORD_W-1:0] shiftLo;   // dividend low bits shifting out, quotient bits shifting in
  logic              negQuo;
  logic              negRem;

  // Outputs
  logic [WORD_W-1:0] quoReg;
  logic [WORD_W-1:0] remReg;
  logic              zeroFlag;
  logic              ovfFlag;

  // Magnitudes of the captured operands
  logic              dvdNeg;
  logic              dvsNeg;
  logic [DVD_W-1:0]  dvdMag;
  logic [WORD_W-1:0] dvsMag;

  divMagnitude #(.W(DVD_W)) u_dvdMag (
    .value    (dvdReg),
    .negative (dvdNeg),
    .magnitude(dvdMag)
  );

  divMagnitude #(.W(WORD_W)) u_dvsMag (
    .value    (dvsReg),
    .negative (dvsNeg),
    .magnitude(dvsMag)
  );

  // Setup screening: a zero divisor, or an upper half that already reaches
  // the divisor (quotient of 2^WORD_W or more).
  logic zeroDet;
  logic bigDet;
  assign zeroDet   = (dvsReg == '0);
  assign bigDet    = (dvdMag[DVD_W-1:WORD_W] >= dvsMag);
  assign setupFail = zeroDet | bigDet;

  // One restoring step
  logic [WORD_W:0]   trial;
  logic [WORD_W:0]   dvsExt;
  logic [WORD_W:0]   diff;
  logic              fits;
  logic [WORD_W-1:0] nextRem;

  always_comb begin
    trial   = {partRem, shiftLo[WORD_W-1]};
    dvsExt  = {1'b0, dvsMag};
    diff    = trial - dvsExt;
    fits    = (trial >= dvsExt);
    nextRem = fits ? diff[WORD_W-1:0] : trial[WORD_W-1:0];
  end

  // Final stage: a magnitude with its top bit set is only legal as -2^(WORD_W-1)
  logic              lateOvf;
  logic [WORD_W-1:0] signedQuo;
  logic [WORD_W-1:0] signedRem;

  always_comb begin
    lateOvf   = shiftLo[WORD_W-1] && !(negQuo && (shiftLo == MSB_ONLY));
    signedQuo = negQuo ? (~shiftLo + WORD_W'(1)) : shiftLo;
    signedRem = negRem ? (~partRem + WORD_W'(1)) : partRem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvdReg   <= '0;
      dvsReg   <= '0;
      partRem  <= '0;
      shiftLo  <= '0;
      negQuo   <= 1'b0;
      negRem   <= 1'b0;
      quoReg   <= '0;
      remReg   <= '0;
      zeroFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else if (strobes.load) begin
      dvdReg   <= dividend;
      dvsReg   <= divisor;
      zeroFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else if (strobes.setup) begin
      if (zeroDet)     zeroFlag <= 1'b1;
      else if (bigDet) ovfFlag  <= 1'b1;
      partRem <= dvdMag[DVD_W-1:WORD_W];
      shiftLo <= dvdMag[WORD_W-1:0];
      negQuo  <= dvdNeg ^ dvsNeg;
      negRem  <= dvdNeg;
    end else if (strobes.step) begin
      partRem <= nextRem;
      shiftLo <= {shiftLo[WORD_W-2:0], fits};
    end else if (strobes.fix) begin
      if (lateOvf) begin
        ovfFlag <= 1'b1;
      end else begin
        quoReg <= signedQuo;
        remReg <= signedRem;
      end
    end
  end

  assign quotient   = quoReg;
  assign remainder  = remReg;
  assign zeroDivide = zeroFlag;
  assign overflow   = ovfFlag;
endmodule

// File: rtl/signedDivider.sv
module signedDivider
  import divPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2*WORD_W-1:0] dividend,
  input  logic [WORD_W-1:0]   divisor,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   quotient,
  output logic [WORD_W-1:0]   remainder,
  output logic                zeroDivide,
  output logic                overflow
);
  divStrobes_t strobes;
  logic        setupFail;

  divControl #(.WORD_W(WORD_W)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .setupFail(setupFail),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  divDatapath #(.WORD_W(WORD_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dividend  (dividend),
    .divisor   (divisor),
    .setupFail (setupFail),
    .quotient  (quotient),
    .remainder (remainder),
    .zeroDivide(zeroDivide),
    .overflow  (overflow)
  );
endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] quotient,
  input logic [WORD_W-1:0] remainder,
  input logic              zeroDivide,
  input logic              overflow
);
  localparam logic [7:0] LAT_SHORT = 8'd2;
  localparam logic [7:0] LAT_FULL  = 8'(WORD_W + 3);

  // Edges since the last accepted start (value seen at the sampling edge).
  logic [7:0] lat;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lat <= '0;
    else if (start && !busy)   lat <= 8'd1;
    else if (lat != 8'hFF)     lat <= lat + 8'd1;
  end

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_flags_cleared_R11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (!zeroDivide && !overflow));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(zeroDivide && overflow));

  assert_zero_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && zeroDivide) |-> (lat == LAT_SHORT));

  assert_full_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !zeroDivide && !overflow) |-> (lat == LAT_FULL));

  assert_ovf_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> (lat == LAT_SHORT || lat == LAT_FULL));

  assert_hold_on_error_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && (zeroDivide || overflow)) |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind signedDivider divChecker #(.WORD_W(WORD_W)) u_divChecker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .zeroDivide(zeroDivide),
  .overflow  (overflow)
);

// File: tb/test_signedDivider.sv
`timescale 1ns/1ps
module test_signedDivider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, zeroDivide, overflow;
  logic [31:0] quotient, remainder;

  signedDivider i_signedDivider (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .zeroDivide(zeroDivide), .overflow(overflow)
  );

  always #4 clk = ~clk;   // 125 MHz

  int cycleCnt = 0;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] heldRem = '0;
  logic [31:0] heldQuo = '0;

  typedef struct {
    logic [31:0] rem;
    logic [31:0] quo;
    logic        zd;
    logic        ov;
    int          due;
    string       req;
  } expItem_t;
  expItem_t pending[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // Driver: computes the expected item, queues it, pulses start.
  task automatic issue(input logic [63:0] dvd, input logic [31:0] dvs, input string req);
    expItem_t it;
    logic signed [64:0] a, b, qq, rr, qmag;
    @(negedge clk);
    while (busy) @(negedge clk);
    a = {dvd[63], dvd};
    b = {{33{dvs[31]}}, dvs};
    it.req = req; it.zd = 1'b0; it.ov = 1'b0; it.rem = heldRem; it.quo = heldQuo;
    if (dvs == '0) begin
      it.zd = 1'b1; it.due = cycleCnt + 2;
    end else begin
      qq = a / b;
      rr = a % b;
      qmag = (qq < 0) ? -qq : qq;
      if (qmag >= 65'sd4294967296) begin
        it.ov = 1'b1; it.due = cycleCnt + 2;
      end else begin
        it.due = cycleCnt + 35;
        if (qq > 65'sd2147483647 || qq < -65'sd2147483648) it.ov = 1'b1;
        else begin
          it.quo = qq[31:0];
          it.rem = rr[31:0];
        end
      end
    end
    heldRem = it.rem;
    heldQuo = it.quo;
    pending.push_back(it);
    dividend = dvd;
    divisor  = dvs;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!zeroDivide && !overflow, "R11", "flags after accepted start",
          {62'd0, zeroDivide, overflow}, 64'd0);
  endtask

  // Monitor: pops and compares whenever done is seen.
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        check(!busy, "R10", "busy during done", {63'd0, busy}, 64'd0);
        if (pending.size() == 0) begin
          check(1'b0, "R9", "done with nothing pending", 64'd1, 64'd0);
        end else begin
          it = pending.pop_front();
          check(cycleCnt == it.due, "R10", "done cycle", 64'(cycleCnt), 64'(it.due));
          check(quotient == it.quo, it.req, "quotient", {32'd0, quotient}, {32'd0, it.quo});
          check(remainder == it.rem, it.req, "remainder", {32'd0, remainder}, {32'd0, it.rem});
          check(zeroDivide == it.zd, it.req, "zeroDivide", {63'd0, zeroDivide}, {63'd0, it.zd});
          check(overflow == it.ov, it.req, "overflow", {63'd0, overflow}, {63'd0, it.ov});
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R10 watchdog: actual pending %0d expected 0", pending.size());
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !zeroDivide && !overflow, "R11", "reset flags",
          {60'd0, busy, done, zeroDivide, overflow}, 64'd0);
    check(quotient == '0 && remainder == '0, "R11", "reset results",
          {quotient, remainder}, 64'd0);

    issue(64'd19, 32'd5, "R1");
    issue(64'd100, 32'd8, "R1");
    issue(64'd100, 32'd10, "R1");
    issue(-64'sd100, -32'sd8, "R3");
    issue(-64'sd19, 32'd5, "R2");
    issue(64'd19, -32'sd5, "R3");
    issue(64'd0, -32'sd7, "R2");
    issue(64'd100, 32'd0, "R4/R8");
    issue(64'h0000_0001_0000_0000, 32'd1, "R5/R8");
    issue(64'h8000_0000_0000_0000, 32'hFFFF_FFFF, "R5");
    issue(64'h7FFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF, "R5");
    issue(64'd77, 32'd9, "R1");
    issue(64'h0000_0000_8000_0000, 32'd1, "R6/R8");
    issue(64'hFFFF_FFFF_8000_0000, 32'hFFFF_FFFF, "R6");
    issue(64'h3FFF_FFFF_8000_0000, 32'h7FFF_FFFF, "R6");
    issue(64'hFFFF_FFFF_8000_0000, 32'd1, "R7");
    issue(64'hC000_0000_8000_0000, 32'h7FFF_FFFF, "R7");
    issue(64'h3FFF_FFFF_FFFF_FFFF, 32'h8000_0000, "R2");

    // Stray start while busy must be ignored
    issue(64'd1000, 32'd7, "R9");
    repeat (4) @(negedge clk);
    dividend = 64'd5;
    divisor  = 32'd0;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R9", "busy after stray start", {63'd0, busy}, 64'd1);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] lo, dv;
      lo = $urandom;
      dv = ($urandom % 1000) + 1;
      if (i % 3 == 1) dv = -dv;
      if (i % 4 == 3) issue({$urandom, lo}, $urandom, "R2");
      else            issue({{32{lo[31]}}, lo}, dv, "R3");
    end

    while (pending.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule